// File: doc/BRIEF.md
# Prefix Operand Redirection Unit

This unit sits beside the instruction decoder of a small 4-bit processor. Some instructions are prefixes: they do no work of their own but name a different source register, a different destination register, or a fixed word of RAM page 0 for the processing instruction that follows. The unit keeps one latch for each of these three redirections. Each latch has a valid bit. From the latches it produces the operand selections that the datapath actually uses.

While a latch is valid, its value replaces the decoder's default selection. While it is not valid, the default passes straight through. Only the first prefix of each kind is kept; later prefixes of the same kind are dropped. The processing instruction uses the latched values in the cycle in which it completes, and all latches are invalid from the next cycle on.

The unit also maps each effective register code to a register class, so the datapath can steer the operand without decoding the code again.

Top module: `opnd_redirect_unit`

## Requirements
- R1: A source prefix (`pfx_kind` = 1) loads its operand into the source latch, and a destination prefix (`pfx_kind` = 2) loads its operand into the destination latch. A combined prefix (`pfx_kind` = 3) loads the same operand into both latches. From the next cycle, `src_code` and `dst_code` show the latched values and `src_redir` and `dst_redir` are 1.
- R2: A memory prefix (`pfx_kind` = 4) latches a page-0 word address. While that latch is valid, `ram_addr` equals the latched address with all page bits zero, and `h_ptr` and `l_ptr` have no effect on it.
- R3: A prefix of a kind whose latch is already valid leaves that latch unchanged, so the first value wins. A combined prefix that arrives after a source prefix therefore loads only the destination latch.
- R4: Prefixes of different kinds accumulate. Source, destination and memory redirections can all be in force together for one processing instruction.
- R5: In the cycle where `proc_done` is 1, the outputs still reflect the latches, and from the next cycle all three latches are invalid. A prefix presented in the same cycle as `proc_done` is discarded.
- R6: For each field with no valid latch, the output follows the default input in the same cycle. `src_code` follows `dflt_src`, `dst_code` follows `dflt_dst`, and `ram_addr` is {`h_ptr`, `l_ptr`}.
- R7: `src_cls` and `dst_cls` encode the class of the effective code as follows:
  - code 0 gives class 0 (accumulator), code 1 gives 1 (status), code 2 gives 2 (L pointer), code 3 gives 3 (RAM at pointer), code 4 gives 4 (input port 0), code 5 gives 5 (null), code 6 gives 6 (I/O port 0), code 7 gives 7 (I/O port 1), and code A gives 8 (H pointer).
  - code C gives 9 (I/O port 2) when `ALT_PORT_IS_OUT3` is 0, and 10 (output port 3) when it is 1.
  - codes 8, 9, B, D, E and F give 15 (none).
- R8: Synchronous reset makes all three latches invalid. `pfx_kind` values 0, 5, 6 and 7 load no latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pfx_kind | input | 3 | Decoded prefix kind: 0 none, 1 source, 2 destination, 3 both, 4 memory |
| pfx_arg | input | 4 | Operand of the prefix (register code or page-0 address) |
| proc_done | input | 1 | Processing instruction completes in this cycle |
| dflt_src | input | 4 | Decoder's default source code |
| dflt_dst | input | 4 | Decoder's default destination code |
| h_ptr | input | HPTR_W | RAM page pointer |
| l_ptr | input | LPTR_W | RAM word pointer |
| src_code | output | 4 | Effective source code |
| dst_code | output | 4 | Effective destination code |
| src_cls | output | 4 | Class of the effective source |
| dst_cls | output | 4 | Class of the effective destination |
| ram_addr | output | HPTR_W+LPTR_W | Effective RAM address |
| src_redir | output | 1 | Source latch valid |
| dst_redir | output | 1 | Destination latch valid |
| mem_redir | output | 1 | Memory latch valid |

## Verification
The bench instantiates the unit twice with a 3-bit page pointer and a 4-bit word pointer, one copy with `ALT_PORT_IS_OUT3` at 0 and one with it at 1. This puts both meanings of code C within reach in the same run. It also makes every non-zero page visible, so a memory redirection that failed to force page 0 would show up in `ram_addr`. Random prefix streams with a low completion rate produce long chains of duplicate and combined prefixes, which reach the first-wins cases.

// File: rtl/opnd_redirect_pkg.sv
`timescale 1ns/1ps
package opnd_redirect_pkg;

    localparam int CODE_W    = 4;
    localparam int KIND_W    = 3;
    localparam int NUM_SLOTS = 3;

    // slot indices
    localparam int SLOT_SRC = 0;
    localparam int SLOT_DST = 1;
    localparam int SLOT_MEM = 2;

    typedef enum logic [KIND_W-1:0] {
        PFX_NONE = 3'd0,
        PFX_SRC  = 3'd1,
        PFX_DST  = 3'd2,
        PFX_BOTH = 3'd3,
        PFX_MEM  = 3'd4
    } pfx_kind_e;

    typedef enum logic [CODE_W-1:0] {
        CLS_ACC  = 4'd0,
        CLS_STAT = 4'd1,
        CLS_LPTR = 4'd2,
        CLS_RAM  = 4'd3,
        CLS_IN0  = 4'd4,
        CLS_NULL = 4'd5,
        CLS_IO0  = 4'd6,
        CLS_IO1  = 4'd7,
        CLS_HPTR = 4'd8,
        CLS_IO2  = 4'd9,
        CLS_OUT3 = 4'd10,
        CLS_NONE = 4'd15
    } reg_cls_e;

    typedef struct packed {
        logic              valid;
        logic [CODE_W-1:0] value;
    } pfx_slot_t;

    function automatic logic kind_loads_src(input logic [KIND_W-1:0] k);
        return (k == PFX_SRC) || (k == PFX_BOTH);
    endfunction

    function automatic logic kind_loads_dst(input logic [KIND_W-1:0] k);
        return (k == PFX_DST) || (k == PFX_BOTH);
    endfunction

    function automatic logic kind_loads_mem(input logic [KIND_W-1:0] k);
        return k == PFX_MEM;
    endfunction

    function automatic reg_cls_e code_to_cls(input logic [CODE_W-1:0] c,
                                             input logic alt_out3);
        reg_cls_e r;
        case (c)
            4'h0:    r = CLS_ACC;
            4'h1:    r = CLS_STAT;
            4'h2:    r = CLS_LPTR;
            4'h3:    r = CLS_RAM;
            4'h4:    r = CLS_IN0;
            4'h5:    r = CLS_NULL;
            4'h6:    r = CLS_IO0;
            4'h7:    r = CLS_IO1;
            4'hA:    r = CLS_HPTR;
            4'hC:    r = alt_out3 ? CLS_OUT3 : CLS_IO2;
            default: r = CLS_NONE;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/opnd_pfx_slot.sv
`timescale 1ns/1ps
module opnd_pfx_slot
    import opnd_redirect_pkg::*;
#(
    parameter int W = CODE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_i,
    input  logic         ld_i,
    input  logic [W-1:0] data_i,
    output logic         valid_o,
    output logic [W-1:0] value_o
);

    logic         valid_q;
    logic [W-1:0] value_q;
    logic         take;

    // first value of a kind wins: load only into an empty slot
    assign take = ld_i && !valid_q && !clr_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            value_q <= '0;
        end else if (clr_i) begin
            valid_q <= 1'b0;
        end else if (take) begin
            valid_q <= 1'b1;
            value_q <= data_i;
        end
    end

    assign valid_o = valid_q;
    assign value_o = value_q;

    AST_SLOT_LOAD: assert property (@(posedge clk) disable iff (rst)
        (ld_i && !valid_q && !clr_i) |=> (valid_q && value_q == $past(data_i))); // R1

    AST_SLOT_FIRST_WINS: assert property (@(posedge clk) disable iff (rst)
        (valid_q && !clr_i) |=> (valid_q && value_q == $past(value_q))); // R3

    AST_SLOT_CLEAR: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> !valid_q); // R5

    AST_SLOT_RESET: assert property (@(posedge clk)
        rst |=> !valid_q); // R8

endmodule

// File: rtl/opnd_cls_decode.sv
`timescale 1ns/1ps
module opnd_cls_decode
    import opnd_redirect_pkg::*;
#(
    parameter bit ALT_PORT_IS_OUT3 = 1'b0
) (
    input  logic [CODE_W-1:0] code_i,
    output logic [CODE_W-1:0] cls_o
);

    reg_cls_e cls;

    always_comb begin
        cls   = code_to_cls(code_i, ALT_PORT_IS_OUT3);
        cls_o = cls;
    end

endmodule

// File: rtl/opnd_ram_addr_sel.sv
`timescale 1ns/1ps
module opnd_ram_addr_sel #(
    parameter int HPTR_W = 3,
    parameter int LPTR_W = 4
) (
    input  logic                     mem_v_i,
    input  logic [LPTR_W-1:0]        mem_a_i,
    input  logic [HPTR_W-1:0]        h_i,
    input  logic [LPTR_W-1:0]        l_i,
    output logic [HPTR_W+LPTR_W-1:0] addr_o
);

    localparam int AW = HPTR_W + LPTR_W;

    logic [AW-1:0] ptr_addr;
    logic [AW-1:0] page0_addr;

    assign ptr_addr   = {h_i, l_i};
    assign page0_addr = {{HPTR_W{1'b0}}, mem_a_i};

    always_comb begin
        if (mem_v_i) addr_o = page0_addr;
        else         addr_o = ptr_addr;
    end

endmodule

// File: rtl/opnd_redirect_unit.sv
`timescale 1ns/1ps
module opnd_redirect_unit
    import opnd_redirect_pkg::*;
#(
    parameter int HPTR_W           = 3,
    parameter int LPTR_W           = 4,
    parameter bit ALT_PORT_IS_OUT3 = 1'b0
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [2:0]               pfx_kind,
    input  logic [3:0]               pfx_arg,
    input  logic                     proc_done,
    input  logic [3:0]               dflt_src,
    input  logic [3:0]               dflt_dst,
    input  logic [HPTR_W-1:0]        h_ptr,
    input  logic [LPTR_W-1:0]        l_ptr,
    output logic [3:0]               src_code,
    output logic [3:0]               dst_code,
    output logic [3:0]               src_cls,
    output logic [3:0]               dst_cls,
    output logic [HPTR_W+LPTR_W-1:0] ram_addr,
    output logic                     src_redir,
    output logic                     dst_redir,
    output logic                     mem_redir
);

    localparam int AW = HPTR_W + LPTR_W;

    logic [NUM_SLOTS-1:0] slot_ld;
    pfx_slot_t            slot [NUM_SLOTS];

    always_comb begin
        slot_ld           = '0;
        slot_ld[SLOT_SRC] = kind_loads_src(pfx_kind);
        slot_ld[SLOT_DST] = kind_loads_dst(pfx_kind);
        slot_ld[SLOT_MEM] = kind_loads_mem(pfx_kind);
    end

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        logic              v;
        logic [CODE_W-1:0] q;
        opnd_pfx_slot #(.W(CODE_W)) slot_i (
            .clk     (clk),
            .rst     (rst),
            .clr_i   (proc_done),
            .ld_i    (slot_ld[g]),
            .data_i  (pfx_arg),
            .valid_o (v),
            .value_o (q)
        );
        assign slot[g] = '{valid: v, value: q};
    end

    assign src_code  = slot[SLOT_SRC].valid ? slot[SLOT_SRC].value : dflt_src;
    assign dst_code  = slot[SLOT_DST].valid ? slot[SLOT_DST].value : dflt_dst;
    assign src_redir = slot[SLOT_SRC].valid;
    assign dst_redir = slot[SLOT_DST].valid;
    assign mem_redir = slot[SLOT_MEM].valid;

    opnd_cls_decode #(.ALT_PORT_IS_OUT3(ALT_PORT_IS_OUT3)) src_dec_i (
        .code_i (src_code),
        .cls_o  (src_cls)
    );

    opnd_cls_decode #(.ALT_PORT_IS_OUT3(ALT_PORT_IS_OUT3)) dst_dec_i (
        .code_i (dst_code),
        .cls_o  (dst_cls)
    );

    opnd_ram_addr_sel #(.HPTR_W(HPTR_W), .LPTR_W(LPTR_W)) addr_i (
        .mem_v_i (slot[SLOT_MEM].valid),
        .mem_a_i (slot[SLOT_MEM].value[LPTR_W-1:0]),
        .h_i     (h_ptr),
        .l_i     (l_ptr),
        .addr_o  (ram_addr)
    );

    AST_MEM_PTR_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (mem_redir && $past(mem_redir) && !$past(proc_done)) |-> $stable(ram_addr)); // R2

    AST_DONE_CLEARS_ALL: assert property (@(posedge clk) disable iff (rst)
        proc_done |=> !(src_redir || dst_redir || mem_redir)); // R5

    AST_NONLOAD_KIND: assert property (@(posedge clk) disable iff (rst)
        (pfx_kind >= 3'd5 && !src_redir && !proc_done) |=> !src_redir); // R8

    AST_PAGE_ZERO: assert property (@(posedge clk) disable iff (rst)
        mem_redir |-> (ram_addr[AW-1:LPTR_W] == '0)); // R2

endmodule

// File: tb/opnd_redirect_unit_tb.sv
`timescale 1ns/1ps
module opnd_redirect_unit_tb_top;

    localparam int HW = 3;
    localparam int LW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [2:0]    pfx_kind = '0;
    logic [3:0]    pfx_arg = '0;
    logic          proc_done = 1'b0;
    logic [3:0]    dflt_src = '0;
    logic [3:0]    dflt_dst = '0;
    logic [HW-1:0] h_ptr = '0;
    logic [LW-1:0] l_ptr = '0;

    logic [3:0]       src_code, dst_code, src_cls, dst_cls;
    logic [HW+LW-1:0] ram_addr;
    logic             src_redir, dst_redir, mem_redir;
    logic [3:0]       b_src_code, b_dst_code, b_src_cls, b_dst_cls;
    logic [HW+LW-1:0] b_ram_addr;
    logic             b_src_redir, b_dst_redir, b_mem_redir;

    always #5 clk = ~clk;

    opnd_redirect_unit #(.HPTR_W(HW), .LPTR_W(LW), .ALT_PORT_IS_OUT3(1'b0)) dut_i (
        .clk(clk), .rst(rst), .pfx_kind(pfx_kind), .pfx_arg(pfx_arg),
        .proc_done(proc_done), .dflt_src(dflt_src), .dflt_dst(dflt_dst),
        .h_ptr(h_ptr), .l_ptr(l_ptr), .src_code(src_code), .dst_code(dst_code),
        .src_cls(src_cls), .dst_cls(dst_cls), .ram_addr(ram_addr),
        .src_redir(src_redir), .dst_redir(dst_redir), .mem_redir(mem_redir)
    );

    opnd_redirect_unit #(.HPTR_W(HW), .LPTR_W(LW), .ALT_PORT_IS_OUT3(1'b1)) dut_out3_i (
        .clk(clk), .rst(rst), .pfx_kind(pfx_kind), .pfx_arg(pfx_arg),
        .proc_done(proc_done), .dflt_src(dflt_src), .dflt_dst(dflt_dst),
        .h_ptr(h_ptr), .l_ptr(l_ptr), .src_code(b_src_code), .dst_code(b_dst_code),
        .src_cls(b_src_cls), .dst_cls(b_dst_cls), .ram_addr(b_ram_addr),
        .src_redir(b_src_redir), .dst_redir(b_dst_redir), .mem_redir(b_mem_redir)
    );

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    // reference state
    bit       m_sv, m_dv, m_mv;
    bit [3:0] m_s, m_d, m_m;

    function automatic int exp_cls(input bit [3:0] c, input bit out3);
        case (c)
            4'h0, 4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'h7: return int'(c);
            4'hA: return 8;
            4'hC: return out3 ? 10 : 9;
            default: return 15;
        endcase
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        int es, ed, ea;
        es = m_sv ? int'(m_s) : int'(dflt_src);
        ed = m_dv ? int'(m_d) : int'(dflt_dst);
        ea = m_mv ? int'(m_m) : int'({h_ptr, l_ptr});
        chk(tag, "src_code", int'(src_code), es);
        chk(tag, "dst_code", int'(dst_code), ed);
        chk(tag, "ram_addr", int'(ram_addr), ea);
        chk(tag, "redir", int'({src_redir, dst_redir, mem_redir}), int'({m_sv, m_dv, m_mv}));
        chk(tag, "src_cls", int'(src_cls), exp_cls(4'(es), 1'b0));
        chk(tag, "dst_cls", int'(dst_cls), exp_cls(4'(ed), 1'b0));
        chk(tag, "src_cls_out3", int'(b_src_cls), exp_cls(4'(es), 1'b1));
        chk(tag, "dst_cls_out3", int'(b_dst_cls), exp_cls(4'(ed), 1'b1));
    endtask

    task automatic model_step();
        if (proc_done) begin
            m_sv = 0; m_dv = 0; m_mv = 0;
        end else begin
            if ((pfx_kind == 3'd1 || pfx_kind == 3'd3) && !m_sv) begin m_sv = 1; m_s = pfx_arg; end
            if ((pfx_kind == 3'd2 || pfx_kind == 3'd3) && !m_dv) begin m_dv = 1; m_d = pfx_arg; end
            if (pfx_kind == 3'd4 && !m_mv) begin m_mv = 1; m_m = pfx_arg; end
        end
    endtask

    task automatic cyc(input bit [2:0] k, input bit [3:0] a, input bit d, input string tag);
        @(negedge clk);
        pfx_kind = k; pfx_arg = a; proc_done = d;
        #1;
        compare(tag);
        model_step();
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        m_sv = 0; m_dv = 0; m_mv = 0; m_s = 0; m_d = 0; m_m = 0;
        dflt_src = 4'h0; dflt_dst = 4'h1; h_ptr = 3'd5; l_ptr = 4'd7;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R8 reset state
        cyc(3'd0, 4'h0, 1'b0, "R8");
        // R1 source then destination
        cyc(3'd1, 4'h6, 1'b0, "R1");
        cyc(3'd2, 4'h7, 1'b0, "R1");
        // R3 duplicates lose; combined after source loads only dst (already valid too)
        cyc(3'd1, 4'h2, 1'b0, "R3");
        cyc(3'd3, 4'hA, 1'b0, "R3");
        // R2 memory prefix, pointer moves ignored
        cyc(3'd4, 4'h9, 1'b0, "R2");
        h_ptr = 3'd7; l_ptr = 4'd3;
        cyc(3'd4, 4'h1, 1'b0, "R2");
        h_ptr = 3'd2; l_ptr = 4'd12;
        // R5 completion uses latched values, then clears
        cyc(3'd0, 4'h0, 1'b1, "R5");
        cyc(3'd0, 4'h0, 1'b0, "R5");
        // R5 prefix together with completion is dropped
        cyc(3'd3, 4'hC, 1'b1, "R5");
        cyc(3'd0, 4'h0, 1'b0, "R5");
        // R3 combined after a source prefix
        cyc(3'd1, 4'h4, 1'b0, "R3");
        cyc(3'd3, 4'h3, 1'b0, "R3");
        cyc(3'd0, 4'h0, 1'b1, "R3");
        // R8 non-loading kinds
        cyc(3'd5, 4'h2, 1'b0, "R8");
        cyc(3'd6, 4'h2, 1'b0, "R8");
        cyc(3'd7, 4'h2, 1'b0, "R8");
        cyc(3'd0, 4'h0, 1'b0, "R8");
        // R4 three prefixes together
        cyc(3'd4, 4'hF, 1'b0, "R4");
        cyc(3'd2, 4'hC, 1'b0, "R4");
        cyc(3'd1, 4'h5, 1'b0, "R4");
        cyc(3'd0, 4'h0, 1'b1, "R4");
        // R6 / R7 pass-through and class sweep
        for (int c = 0; c < 16; c++) begin
            dflt_src = 4'(c); dflt_dst = 4'(15 - c);
            h_ptr = 3'(c); l_ptr = 4'(c * 3);
            cyc(3'd0, 4'h0, 1'b0, "R7");
            cyc(3'd0, 4'h0, 1'b0, "R6");
        end
        // R7 class of latched code C on both variants
        cyc(3'd3, 4'hC, 1'b0, "R7");
        cyc(3'd0, 4'h0, 1'b1, "R7");
        // random mix
        for (int i = 0; i < 4000; i++) begin
            dflt_src = 4'($urandom_range(0, 15));
            dflt_dst = 4'($urandom_range(0, 15));
            h_ptr    = 3'($urandom_range(0, 7));
            l_ptr    = 4'($urandom_range(0, 15));
            cyc(3'($urandom_range(0, 7)), 4'($urandom_range(0, 15)),
                ($urandom_range(0, 5) == 0), "R4");
        end
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule